// File: doc/BRIEF.md
# CRC-16 Engine with Block Memory Scan

This block computes a 16-bit cyclic redundancy check over a byte stream using the generator polynomial 0x1021 (x^16 + x^12 + x^5 + 1). Each byte is folded in most significant bit first. The input is not reflected and no final XOR is applied. Software either writes bytes one at a time through a byte port, or starts an automatic scan. The running value is held in a result register that can be read at any time. The register is first loaded with one of two seeds, 0x0000 or 0xFFFF.

The automatic scan walks a read-only memory port over one or more consecutive 256-byte blocks. It folds every returned byte into the running value and then raises a completion flag. The memory port is modelled with one cycle of read latency.

A separate helper returns the bit-reversed form of the last byte written to it. This helper has no effect on the checksum.

Top module: `crc16_scan_engine`

## Requirements
- R1: The generator is 0x1021, MSB first, with no reflection and no final XOR. Folding the ASCII bytes "123456789" (0x31..0x39) gives 0x29B1 after seed 0xFFFF and 0x31C3 after seed 0x0000.
- R2: A byte written with `byteWrEn` updates `crcResult` by one full byte step, visible in the cycle after the write edge. When idle with no write and no init, `crcResult` holds its value.
- R3: When not busy, `initReq` loads 0xFFFF into `crcResult` if `seedSel` is 1 and 0x0000 if it is 0. If `initReq` and `byteWrEn` arrive in the same cycle, the seed load wins.
- R4: `revData` shows the last byte written with `revWrEn`, with bit i moved to bit 7-i.
- R5: A write to the reversal port leaves `crcResult` unchanged.
- R6: `scanStart` with block index B and count N > 0 raises `memRdEn` for exactly N*256 consecutive cycles. The addresses run from B*256 up by one per cycle. Each byte returned one cycle after its request is folded into the current CRC value.
- R7: `scanBusy` is high from the cycle after the start until the last byte is folded. After that `scanDone` is set and stays set until the next `scanStart` or `initReq`. `scanDone` and `scanBusy` are never high together.
- R8: While `scanBusy` is high, `byteWrEn`, `initReq` and `scanStart` are ignored.
- R9: A scan with N = 0 issues no reads, leaves `crcResult` unchanged, and sets `scanDone` in the cycle after the start.
- R10: After reset, `crcResult` is 0x0000, `revData` is 0x00, and `scanBusy`, `scanDone` and `memRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | 1 | Load the selected seed |
| seedSel | input | 1 | Seed choice: 1 = 0xFFFF, 0 = 0x0000 |
| byteWrEn | input | 1 | Fold `byteWrData` into the CRC |
| byteWrData | input | 8 | Byte to fold |
| crcResult | output | 16 | Running CRC value |
| revWrEn | input | 1 | Capture a byte for reversal |
| revWrData | input | 8 | Byte to reverse |
| revData | output | 8 | Bit-reversed form of the captured byte |
| scanStart | input | 1 | Begin an automatic block scan |
| startBlock | input | ADDR_W-8 | Index of the first 256-byte block |
| blockCount | input | ADDR_W-7 | Number of blocks to scan |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memRdData | input | 8 | Read data, valid one cycle after the request |
| scanBusy | output | 1 | Scan in progress |
| scanDone | output | 1 | Scan finished |

## Verification
Any wrong value in the CRC register appears on `crcResult` one cycle after the byte that caused it, and it changes every later value. For this reason the bench compares the result after every single byte write, not only at the end of a sequence. A wrong scan address or read count shows up on `memRdEn` and `memAddr` in the very cycle it happens. A missed or duplicated fold shows up as a wrong `crcResult` when `scanDone` rises, N*256+2 cycles after the start. A wrong seed or reversal value shows up one cycle after the request.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scanState_e;

  typedef struct packed {
    logic loadSeed;
    logic foldByte;
    logic useMem;
  } crcCtl_t;

  // one full byte step, unrolled over eight bit steps, MSB first
  function automatic logic [15:0] crcFold(input logic [15:0] cur, input logic [7:0] din);
    logic [15:0] acc;
    acc = cur;
    for (int b = 7; b >= 0; b--) begin
      if (acc[15] ^ din[b]) acc = {acc[14:0], 1'b0} ^ CRC_POLY;
      else                  acc = {acc[14:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  crcCtl_t     ctl,
  input  logic        seedSel,
  input  logic [7:0]  byteWrData,
  input  logic [7:0]  memRdData,
  input  logic        revWrEn,
  input  logic [7:0]  revWrData,
  output logic [15:0] crcResult,
  output logic [7:0]  revData
);

  logic [15:0] crcReg;
  logic [7:0]  foldIn;
  logic [7:0]  revReg;
  logic [7:0]  revNext;

  assign foldIn = ctl.useMem ? memRdData : byteWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= 16'h0000;
    end else if (ctl.loadSeed) begin
      crcReg <= seedSel ? 16'hFFFF : 16'h0000;
    end else if (ctl.foldByte) begin
      crcReg <= crcFold(crcReg, foldIn);
    end
  end

  generate
    for (genvar i = 0; i < 8; i++) begin : g_rev
      assign revNext[i] = revWrData[7-i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)        revReg <= 8'h00;
    else if (revWrEn) revReg <= revNext;
  end

  assign crcResult = crcReg;
  assign revData   = revReg;

endmodule

// File: rtl/crc16_scan_ctrl.sv
module crc16_scan_ctrl
  import crc16_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                initReq,
  input  logic                byteWrEn,
  input  logic                scanStart,
  input  logic [ADDR_W-9:0]   startBlock,
  input  logic [ADDR_W-8:0]   blockCount,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                scanBusy,
  output logic                scanDone,
  output crcCtl_t             ctl
);

  localparam int CNT_W = ADDR_W + 1;

  scanState_e         state;
  logic [ADDR_W-1:0]  addrReg;
  logic [CNT_W-1:0]   remaining;
  logic               rdPend;
  logic               idle;

  assign idle = (state == SCAN_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SCAN_IDLE;
      addrReg   <= '0;
      remaining <= '0;
      scanDone  <= 1'b0;
      rdPend    <= 1'b0;
    end else begin
      rdPend <= (state == SCAN_RUN);
      case (state)
        SCAN_IDLE: begin
          if (scanStart) begin
            if (blockCount == '0) begin
              scanDone <= 1'b1;
            end else begin
              scanDone  <= 1'b0;
              addrReg   <= {startBlock, 8'h00};
              remaining <= {blockCount, 8'h00};
              state     <= SCAN_RUN;
            end
          end else if (initReq) begin
            scanDone <= 1'b0;
          end
        end
        SCAN_RUN: begin
          addrReg   <= addrReg + 1'b1;
          remaining <= remaining - 1'b1;
          if (remaining == CNT_W'(1)) state <= SCAN_DRAIN;
        end
        SCAN_DRAIN: begin
          state    <= SCAN_IDLE;
          scanDone <= 1'b1;
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadSeed = idle && initReq;
    ctl.foldByte = idle ? (byteWrEn && !initReq) : rdPend;
    ctl.useMem   = !idle;
  end

  assign memRdEn  = (state == SCAN_RUN);
  assign memAddr  = addrReg;
  assign scanBusy = !idle;

endmodule

// File: rtl/crc16_scan_engine.sv
module crc16_scan_engine
  import crc16_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              seedSel,
  input  logic              byteWrEn,
  input  logic [7:0]        byteWrData,
  output logic [15:0]       crcResult,
  input  logic              revWrEn,
  input  logic [7:0]        revWrData,
  output logic [7:0]        revData,
  input  logic              scanStart,
  input  logic [ADDR_W-9:0] startBlock,
  input  logic [ADDR_W-8:0] blockCount,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              scanBusy,
  output logic              scanDone
);

  crcCtl_t ctl;

  crc16_scan_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .initReq    (initReq),
    .byteWrEn   (byteWrEn),
    .scanStart  (scanStart),
    .startBlock (startBlock),
    .blockCount (blockCount),
    .memRdEn    (memRdEn),
    .memAddr    (memAddr),
    .scanBusy   (scanBusy),
    .scanDone   (scanDone),
    .ctl        (ctl)
  );

  crc16_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .seedSel    (seedSel),
    .byteWrData (byteWrData),
    .memRdData  (memRdData),
    .revWrEn    (revWrEn),
    .revWrData  (revWrData),
    .crcResult  (crcResult),
    .revData    (revData)
  );

endmodule

// File: rtl/crc16_scan_checker.sv
module crc16_scan_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              initReq,
  input logic              seedSel,
  input logic              byteWrEn,
  input logic              revWrEn,
  input logic [15:0]       crcResult,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              scanBusy,
  input logic              scanDone
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  // R6: consecutive reads step the address by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + ADDR_ONE));

  // R8: no memory traffic outside a scan
  a_r8_no_read_idle: assert property (@(posedge clk) disable iff (!rstN)
    !scanBusy |-> !memRdEn);

  // R7: done and busy are exclusive
  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !scanBusy);

  // R3: seed load when idle
  a_r3_seed_load: assert property (@(posedge clk) disable iff (!rstN)
    (initReq && !scanBusy) |=> (crcResult == ($past(seedSel) ? 16'hFFFF : 16'h0000)));

  // R5: reversal writes leave the CRC alone
  a_r5_rev_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (revWrEn && !byteWrEn && !initReq && !scanBusy) |=> $stable(crcResult));

  // R2: idle with no request holds the result
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!scanBusy && !byteWrEn && !initReq) |=> $stable(crcResult));

endmodule

bind crc16_scan_engine crc16_scan_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .initReq   (initReq),
  .seedSel   (seedSel),
  .byteWrEn  (byteWrEn),
  .revWrEn   (revWrEn),
  .crcResult (crcResult),
  .memRdEn   (memRdEn),
  .memAddr   (memAddr),
  .scanBusy  (scanBusy),
  .scanDone  (scanDone)
);

// File: tb/test_crc16_scan_engine.sv
module test_crc16_scan_engine;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              initReq = 1'b0, seedSel = 1'b0, byteWrEn = 1'b0;
  logic [7:0]        byteWrData = 8'h00;
  logic [15:0]       crcResult;
  logic              revWrEn = 1'b0;
  logic [7:0]        revWrData = 8'h00, revData;
  logic              scanStart = 1'b0;
  logic [ADDR_W-9:0] startBlock = '0;
  logic [ADDR_W-8:0] blockCount = '0;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memRdData = 8'h00;
  logic              scanBusy, scanDone;

  int checks = 0, fails = 0;
  int rdCount = 0, addrErr = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic [15:0] model = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_scan_engine #(.ADDR_W(ADDR_W)) i_crc16_scan_engine (.*);

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) memRdData <= memByte(memAddr);

  always @(negedge clk) begin
    if (memRdEn) begin
      if (memAddr != expAddr) addrErr++;
      expAddr <= memAddr + 1'b1;
      rdCount++;
    end
  end

  // reference: bitwise long division, remainder register kept separate
  function automatic logic [15:0] refCrc(input logic [15:0] r, input logic [7:0] d);
    logic [15:0] x;
    x = r ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); byteWrEn = 1'b1; byteWrData = d;
    @(negedge clk); byteWrEn = 1'b0;
  endtask

  task automatic doInit(input logic s);
    @(negedge clk); initReq = 1'b1; seedSel = s;
    @(negedge clk); initReq = 1'b0;
  endtask

  // bit9 = init, bit8 = seed choice, [7:0] = byte
  localparam logic [9:0] VEC [0:21] = '{
    10'h300, 10'h031, 10'h032, 10'h033, 10'h034, 10'h035, 10'h036, 10'h037, 10'h038, 10'h039,
    10'h200, 10'h031, 10'h032, 10'h033, 10'h034, 10'h035, 10'h036, 10'h037, 10'h038, 10'h039,
    10'h0FF, 10'h000
  };

  task automatic runScan(input int blk, input int cnt, input bit poke);
    int guard;
    @(negedge clk);
    expAddr = ADDR_W'(blk * 256); rdCount = 0; addrErr = 0;
    scanStart = 1'b1; startBlock = (ADDR_W-8)'(blk); blockCount = (ADDR_W-7)'(cnt);
    @(negedge clk); scanStart = 1'b0;
    check("R7 busy after start", {15'd0, scanBusy}, (cnt > 0) ? 16'd1 : 16'd0);
    guard = 0;
    while (!scanDone && guard < 5000) begin
      if (poke && guard == 20) begin
        byteWrEn = 1'b1; byteWrData = 8'hAA; initReq = 1'b1; seedSel = 1'b1; scanStart = 1'b1;
      end else begin
        byteWrEn = 1'b0; initReq = 1'b0; scanStart = 1'b0;
      end
      @(negedge clk);
      guard++;
      if (scanBusy && scanDone) check("R7 exclusive", 16'd1, 16'd0);
    end
    byteWrEn = 1'b0; initReq = 1'b0; scanStart = 1'b0;
    check("R7 done flag", {15'd0, scanDone}, 16'd1);
    check("R7 busy cleared", {15'd0, scanBusy}, 16'd0);
    check("R6 read count", 16'(rdCount), 16'(cnt * 256));
    check("R6 address sequence", 16'(addrErr), 16'd0);
    for (int a = blk * 256; a < (blk + cnt) * 256; a++) model = refCrc(model, memByte(ADDR_W'(a)));
    check(poke ? "R8 ignored during scan" : "R6 scan result", crcResult, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 crc", crcResult, 16'h0000);
    check("R10 rev", {8'h00, revData}, 16'h0000);
    check("R10 flags", {13'd0, scanBusy, scanDone, memRdEn}, 16'h0000);

    // table walk: R1/R2/R3
    foreach (VEC[i]) begin
      if (VEC[i][9]) begin
        doInit(VEC[i][8]);
        model = VEC[i][8] ? 16'hFFFF : 16'h0000;
        check("R3 seed load", crcResult, model);
      end else begin
        writeByte(VEC[i][7:0]);
        model = refCrc(model, VEC[i][7:0]);
        check("R2 byte fold", crcResult, model);
      end
      if (i == 9)  check("R1 check value FFFF", crcResult, 16'h29B1);
      if (i == 19) check("R1 check value 0000", crcResult, 16'h31C3);
    end

    // R2 hold with no write
    repeat (3) @(negedge clk);
    check("R2 hold", crcResult, model);

    // R3 init beats a same-cycle write
    @(negedge clk); initReq = 1'b1; seedSel = 1'b1; byteWrEn = 1'b1; byteWrData = 8'h12;
    @(negedge clk); initReq = 1'b0; byteWrEn = 1'b0;
    model = 16'hFFFF;
    check("R3 init priority", crcResult, model);

    // R4/R5 reversal
    @(negedge clk); revWrEn = 1'b1; revWrData = 8'h01;
    @(negedge clk); revWrData = 8'hA6;
    check("R4 reverse 01", {8'h00, revData}, 16'h0080);
    @(negedge clk); revWrEn = 1'b0;
    check("R4 reverse A6", {8'h00, revData}, 16'h0065);
    check("R5 crc untouched", crcResult, model);

    // scans
    runScan(2, 1, 1'b0);
    runScan(5, 2, 1'b1);
    runScan(0, 0, 1'b0);   // R9: empty scan leaves crc unchanged
    check("R9 crc unchanged", crcResult, model);

    // R7 init clears done
    doInit(1'b0);
    model = 16'h0000;
    check("R7 done cleared by init", {15'd0, scanDone}, 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule